// File: doc/BRIEF.md
# Host/Management Byte Mailbox with Keyboard-Controller-Style Status

This block lets a host processor and a management controller pass single bytes to each other through two one-byte buffers, one per direction. The host-to-management buffer is the inbound byte. The management-to-host buffer is the outbound byte. Each buffer is controlled by a small two-state machine.

| State | Meaning |
|---|---|
| `BUF_EMPTY` | The buffer holds no unread byte. |
| `BUF_FULL` | The buffer holds a byte that the far side has not yet read. |

| Transition | From → To | Cause |
|---|---|---|
| LOAD | `BUF_EMPTY` → `BUF_FULL` | The writing side writes a byte. |
| OVERWRITE | `BUF_FULL` → `BUF_FULL` | The writing side writes again, including in the same cycle as a read. |
| DRAIN | `BUF_FULL` → `BUF_EMPTY` | The reading side reads and there is no write in that cycle. |

Both sides can read an eight-bit status byte. The hardware owns three bits of it: the outbound-full flag, the inbound-full flag and a flag that records the address of the last host write. The management side owns the remaining bits, and only a management write can change them. Each side has an interrupt output that is asserted while the buffer it must service is full, and the management side can mask each interrupt.

Read data is combinational from the registers, so it is valid in the same cycle as the read strobe. All side effects of a read or a write take place at the next rising clock edge.

Top module: `kcs_mailbox`

## Requirements
- R1: A host write to either host address stores `host_wdata` in the inbound byte and sets status bit 1 (inbound full). A management read at `mc_addr`=0 returns the inbound byte and clears status bit 1 at the next edge.
- R2: A management write at `mc_addr`=0 stores the outbound byte and sets status bit 0 (outbound full). A host read at `host_addr`=0 returns the outbound byte and clears status bit 0 at the next edge.
- R3: After a host write, status bit 3 holds the write address: 1 for `host_addr`=1 (command) and 0 for `host_addr`=0 (data).
- R4: A management write at `mc_addr`=1 loads status bits 7:4 and 2 from `mc_wdata`. It leaves bits 0, 1 and 3 unchanged.
- R5: No host access changes status bits 7:4 or 2. A host read at `host_addr`=1 has no side effect on any state.
- R6: `mc_irq` equals inbound-full AND enable bit 0. `host_irq` equals outbound-full AND enable bit 1. The enable bits are written at `mc_addr`=2 from `mc_wdata[1:0]` and are read back there in bits 1:0, with the upper bits reading 0.
- R7: A write and a read of the same buffer in one cycle leave the buffer full and store the new byte. A read in that cycle returns the old byte.
- R8: After reset both data bytes, all status bits and both enables are zero, and both interrupts are low.
- R9: The host at `host_addr`=1 and the management side at `mc_addr`=1 both read the same status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 1 | Host address: 0 selects data, 1 selects command (write) or status (read) |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data: the outbound byte or the status byte |
| host_irq | output | 1 | Host interrupt: outbound full and enabled |
| mc_addr | input | 2 | Management address: 0 selects the data byte, 1 the status byte, 2 the interrupt enables |
| mc_wr | input | 1 | Management write strobe |
| mc_rd | input | 1 | Management read strobe |
| mc_wdata | input | 8 | Management write data |
| mc_rdata | output | 8 | Management read data |
| mc_irq | output | 1 | Management interrupt: inbound full and enabled |

## Verification
A write by one side and a read of the same buffer by the other side can fall in the same clock cycle. When they do, the write must win: the full flag stays set and the new byte is kept. The bench forces this case in directed steps for both directions. It also produces it often in a long stretch of random strobes.

In every cycle the bench compares each read port and interrupt against a behavioural model. In a collision cycle it checks that the read returns the old byte. In the next cycle it checks that the full flag is still set and that the new byte is in place.

// File: rtl/kcs_pkg.sv
package kcs_pkg;
    localparam int DATA_W      = 8;
    localparam int OBF_BIT     = 0;
    localparam int IBF_BIT     = 1;
    localparam int CMD_BIT     = 3;
    localparam logic [DATA_W-1:0] HW_MASK = (DATA_W'(1) << OBF_BIT)
                                          | (DATA_W'(1) << IBF_BIT)
                                          | (DATA_W'(1) << CMD_BIT);
    localparam logic [DATA_W-1:0] SW_MASK = ~HW_MASK;

    localparam logic [1:0] MC_A_DATA = 2'd0;
    localparam logic [1:0] MC_A_STAT = 2'd1;
    localparam logic [1:0] MC_A_IREN = 2'd2;

    typedef enum logic {
        BUF_EMPTY = 1'b0,
        BUF_FULL  = 1'b1
    } buf_state_e;
endpackage

// File: rtl/kcs_channel.sv
module kcs_channel
    import kcs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic         full,
    output logic [W-1:0] data
);
    buf_state_e   state_q, state_d;
    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUF_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_en) begin
            data_q <= wr_data;
        end
    end

    // Next state: LOAD, OVERWRITE (the write wins a collision), DRAIN.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_EMPTY: if (wr_en)           state_d = BUF_FULL;
            BUF_FULL:  if (rd_en && !wr_en) state_d = BUF_EMPTY;
            default:                        state_d = BUF_EMPTY;
        endcase
    end

    always_comb begin
        full = (state_q == BUF_FULL);
        data = data_q;
    end

    AST_FILL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (full && data == $past(wr_data)));                   // R1
    AST_DRAIN_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> !full);                                   // R2
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> full);                                     // R7
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(data));                                      // R7
endmodule

// File: rtl/kcs_status.sv
module kcs_status
    import kcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_cmd,
    input  logic              sw_wr,
    input  logic              en_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              cmd_flag,
    output logic [DATA_W-1:0] sw_bits,
    output logic [1:0]        irq_en
);
    logic              cmd_q;
    logic [DATA_W-1:0] sw_q;
    logic [1:0]        en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= 1'b0;
            sw_q  <= '0;
            en_q  <= '0;
        end else begin
            if (host_wr) cmd_q <= host_cmd;
            if (sw_wr)   sw_q  <= wdata & SW_MASK;
            if (en_wr)   en_q  <= wdata[1:0];
        end
    end

    always_comb begin
        cmd_flag = cmd_q;
        sw_bits  = sw_q;
        irq_en   = en_q;
    end

    AST_SW_HOST_IMMUNE: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr |=> $stable(sw_bits));                                   // R5
    AST_CMD_TRACKS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (cmd_flag == $past(host_cmd)));                     // R3
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(cmd_flag));                                // R3
endmodule

// File: rtl/kcs_mailbox.sv
module kcs_mailbox
    import kcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_irq,
    input  logic [1:0]        mc_addr,
    input  logic              mc_wr,
    input  logic              mc_rd,
    input  logic [DATA_W-1:0] mc_wdata,
    output logic [DATA_W-1:0] mc_rdata,
    output logic              mc_irq
);
    logic              ibf, obf, cmd_flag;
    logic [DATA_W-1:0] idr, odr, sw_bits, status;
    logic [1:0]        irq_en;
    logic              mc_rd_data, mc_wr_data, mc_wr_stat, mc_wr_iren, host_rd_data;

    always_comb begin
        mc_rd_data   = mc_rd && (mc_addr == MC_A_DATA);
        mc_wr_data   = mc_wr && (mc_addr == MC_A_DATA);
        mc_wr_stat   = mc_wr && (mc_addr == MC_A_STAT);
        mc_wr_iren   = mc_wr && (mc_addr == MC_A_IREN);
        host_rd_data = host_rd && !host_addr;
    end

    kcs_channel #(.W(DATA_W)) u_inbound (
        .clk(clk), .rst_n(rst_n),
        .wr_en(host_wr), .wr_data(host_wdata), .rd_en(mc_rd_data),
        .full(ibf), .data(idr)
    );

    kcs_channel #(.W(DATA_W)) u_outbound (
        .clk(clk), .rst_n(rst_n),
        .wr_en(mc_wr_data), .wr_data(mc_wdata), .rd_en(host_rd_data),
        .full(obf), .data(odr)
    );

    kcs_status u_status (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_cmd(host_addr),
        .sw_wr(mc_wr_stat), .en_wr(mc_wr_iren), .wdata(mc_wdata),
        .cmd_flag(cmd_flag), .sw_bits(sw_bits), .irq_en(irq_en)
    );

    always_comb begin
        status          = sw_bits;
        status[OBF_BIT] = obf;
        status[IBF_BIT] = ibf;
        status[CMD_BIT] = cmd_flag;
    end

    always_comb begin
        host_rdata = host_addr ? status : odr;
        unique case (mc_addr)
            MC_A_DATA: mc_rdata = idr;
            MC_A_STAT: mc_rdata = status;
            MC_A_IREN: mc_rdata = {{(DATA_W-2){1'b0}}, irq_en};
            default:   mc_rdata = '0;
        endcase
        mc_irq   = ibf && irq_en[0];
        host_irq = obf && irq_en[1];
    end

    AST_MC_IRQ_NEEDS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
        mc_irq |-> status[IBF_BIT]);                                    // R6
    AST_HOST_IRQ_NEEDS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> status[OBF_BIT]);                                  // R6
    AST_STAT_HW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_wr_stat && !host_wr && !mc_wr_data && !mc_rd_data && !host_rd_data)
        |=> (status[IBF_BIT:OBF_BIT] == $past(status[IBF_BIT:OBF_BIT])
             && status[CMD_BIT] == $past(status[CMD_BIT])));            // R4
    AST_HOST_STAT_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr && !host_wr && !mc_wr && !mc_rd) |=> $stable(status)); // R5
endmodule

// File: tb/tb_kcs_mailbox.sv
module tb_kcs_mailbox;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_addr, host_wr, host_rd;
    logic [7:0] host_wdata, host_rdata, mc_wdata, mc_rdata;
    logic       host_irq, mc_irq, mc_wr, mc_rd;
    logic [1:0] mc_addr;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // behavioural model
    int m_idr, m_odr, m_ibf, m_obf, m_cmd, m_sw, m_en;

    always #4 clk = ~clk;

    kcs_mailbox dut (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .mc_addr(mc_addr), .mc_wr(mc_wr), .mc_rd(mc_rd),
        .mc_wdata(mc_wdata), .mc_rdata(mc_rdata), .mc_irq(mc_irq)
    );

    function automatic int m_status();
        return (m_sw & 'hF4) | (m_cmd << 3) | (m_ibf << 1) | m_obf;
    endfunction

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // One clock: drive after negedge, compare before the edge, update model at the edge.
    task automatic step(input logic hw, input logic hr, input logic ha, input logic [7:0] hd,
                        input logic mw, input logic mr, input logic [1:0] ma, input logic [7:0] md);
        int n_ibf, n_obf;
        host_wr = hw; host_rd = hr; host_addr = ha; host_wdata = hd;
        mc_wr = mw; mc_rd = mr; mc_addr = ma; mc_wdata = md;
        #1;
        check(ha ? "R9" : "R2", host_rdata, ha ? m_status() : m_odr);
        case (ma)
            2'd0: check("R1", mc_rdata, m_idr);
            2'd1: check("R9", mc_rdata, m_status());
            default: check("R6", mc_rdata, m_en);
        endcase
        check("R6", mc_irq,   m_ibf & m_en & 1);
        check("R6", host_irq, m_obf & (m_en >> 1) & 1);
        @(posedge clk);
        n_ibf = m_ibf; n_obf = m_obf;
        if (mr && ma == 2'd0) n_ibf = 0;
        if (hr && !ha)        n_obf = 0;
        if (hw) begin m_idr = hd; n_ibf = 1; m_cmd = ha; end
        if (mw && ma == 2'd0) begin m_odr = md; n_obf = 1; end
        if (mw && ma == 2'd1) m_sw = md & 'hF4;
        if (mw && ma == 2'd2) m_en = md & 3;
        m_ibf = n_ibf; m_obf = n_obf;
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, 0, 8'h00, 0, 0, 2'd1, 8'h00);
    endtask

    initial begin
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 200000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
        mc_wr = 0; mc_rd = 0; mc_addr = 0; mc_wdata = 0;
        m_idr = 0; m_odr = 0; m_ibf = 0; m_obf = 0; m_cmd = 0; m_sw = 0; m_en = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R8 reset state
        check("R8", host_rdata, 0);
        check("R8", mc_rdata, 0);
        check("R8", {host_irq, mc_irq}, 0);
        @(negedge clk);

        // R3 data-address write then command-address write
        step(1, 0, 0, 8'h5A, 0, 0, 2'd1, 8'h00);
        #1; check("R3", mc_rdata, 8'h02); @(negedge clk);
        step(1, 0, 1, 8'hC3, 0, 0, 2'd1, 8'h00);
        #1; check("R3", mc_rdata, 8'h0A); @(negedge clk);
        // R1 management drains the byte
        step(0, 0, 0, 8'h00, 0, 1, 2'd0, 8'h00);
        #1; check("R1", host_rdata, 8'h00); @(negedge clk);
        idle();

        // R4 software bits, hardware bits kept
        step(0, 0, 0, 8'h00, 1, 0, 2'd1, 8'hFF);
        #1; check("R4", mc_rdata, 8'hFC); @(negedge clk);
        step(0, 0, 0, 8'h00, 1, 0, 2'd1, 8'h00);
        #1; check("R4", mc_rdata, 8'h08); @(negedge clk);
        step(0, 0, 0, 8'h00, 1, 0, 2'd1, 8'hA4);

        // R5 host accesses leave software bits alone; status read is quiet
        step(1, 0, 0, 8'h11, 0, 0, 2'd1, 8'h00);
        step(0, 1, 1, 8'h00, 0, 0, 2'd1, 8'h00);
        step(0, 1, 1, 8'h00, 0, 0, 2'd1, 8'h00);
        #1; check("R5", mc_rdata, 8'hA6); @(negedge clk);

        // R6 interrupt enables
        step(0, 0, 0, 8'h00, 1, 0, 2'd2, 8'hFF);
        #1; check("R6", {host_irq, mc_irq}, 2'b01); @(negedge clk);
        step(0, 0, 0, 8'h00, 1, 0, 2'd0, 8'h77);
        #1; check("R6", {host_irq, mc_irq}, 2'b11); @(negedge clk);

        // R7 collision: host write vs management read of the inbound byte
        step(1, 0, 0, 8'h99, 0, 1, 2'd0, 8'h00);
        #1; check("R7", mc_rdata, 8'h99); check("R7", mc_irq, 1); @(negedge clk);
        // R7 collision: management write vs host read of the outbound byte
        step(0, 1, 0, 8'h00, 1, 0, 2'd0, 8'h3C);
        #1; check("R7", host_rdata, 8'h3C); check("R7", host_irq, 1); @(negedge clk);
        step(0, 1, 0, 8'h00, 0, 1, 2'd0, 8'h00);
        #1; check("R2", host_irq, 0); check("R1", mc_irq, 0); @(negedge clk);

        // random stretch compared every clock
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom;
            step(r[0], r[1], r[2], 8'(r[15:8]), r[3], r[4], 2'(r[6:5] % 3), 8'(r[23:16]));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule